// File: doc/BRIEF.md
# I2C Master Packet Command Engine

This block is a single-master I2C controller that runs one byte packet for each command word written to it. The command word names a 7-bit target address and says whether to open with a START and address phase, whether to send or receive a byte, whether a received byte is the last one, and whether to close with a STOP. The engine sequences the whole packet on open-drain SCL/SDA, raises a done flag and records whether the target acknowledged.

A transfer is built from a series of commands. A write sends START plus address with the first byte and STOP with the last. A read asks for bytes one at a time and marks the final one so the master answers it with NACK. A command that has neither a send nor a receive flag is an address probe. When a packet ends without STOP, the engine keeps SCL low and owns the bus, so the next command can open with a repeated START. Bit timing comes from an external strobe: four strobes make one SCL period.

Top module: `i2c_pkt_master`

## Requirements
- R1: A command is accepted only when its enable bit (bit 16) is 1. The other fields are: start = bit 0, transmit = bit 1, receive = bit 3, receive-last = bit 4, stop = bit 5, target address = bits [30:24]. A write with bit 16 at 0 starts nothing and leaves the status and the bus lines unchanged.
- R2: With start set, the engine issues a START and then the address byte, MSB first. The address byte is the 7-bit address followed by R/W, where R/W is 1 for a receive command and 0 otherwise. This also works as a repeated START from a held bus.
- R3: With transmit set, the byte in buffer bits [7:0] is sent MSB first after the address phase, and the target's acknowledge slot is sampled.
- R4: At the end of every accepted command, status bit 16 (done) is set. Bit 1 is set if any acknowledge slot driven by the target was NAK. Bit 0 is set if at least one such slot occurred and none was NAK. An address NAK skips the data byte.
- R5: Writing a 1 to status bit 0, 1 or 16 clears that bit. Bits written with 0 keep their value.
- R6: With receive set, one byte is read into buffer bits [15:8]. The master answers it with ACK, or with NACK when receive-last is set.
- R7: With stop set, a STOP follows the packet and the bus is released. Buffer bit 16 (bus busy) then reads 0 and both line drivers are off.
- R8: Without stop, the engine drives SCL low after the packet and buffer bit 16 stays 1 until a later command ends with STOP.
- R9: A command written while a packet is in progress is ignored.
- R10: Buffer bit 17 shows the synchronised SDA level and bit 18 the synchronised SCL level.
- R11: The engine changes SDA while SCL is high only to form a START or a STOP.
- R12: After reset the status reads 0, bus busy is 0 and neither line is driven.
- R13: A command with start set and neither transmit nor receive performs an address-only probe and reports the address acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Quarter-bit timing strobe |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| txb_we | input | 1 | Transmit byte write strobe |
| txb_wdata | input | 8 | Transmit byte |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask |
| sts_rdata | output | 32 | Status: done (16), NAK (1), ACK (0) |
| buf_rdata | output | 32 | Buffer: SCL (18), SDA (17), busy (16), rx byte [15:8], tx byte [7:0] |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
A packet ends on the strobe that closes its last quarter. The sequencer registers done one cycle after that strobe, and the status register shows it one cycle later still. The bench therefore polls the done bit at falling clock edges and compares the status, buffer and target-model results only once it has seen done. Status clears, ignored commands and line-driver levels are a single register away from the input that causes them, so they are checked at the falling edge after the write. The live-level bits trail the bus by the synchroniser depth. A behavioural target on the open-drain lines records written bytes and the master's acknowledges, which lets the bench check reads, writes, probes and repeated STARTs against values it computes itself.

// File: rtl/i2cpm_pkg.sv
package i2cpm_pkg;
  // command word fields
  localparam int CB_START   = 0;
  localparam int CB_TX      = 1;
  localparam int CB_RX      = 3;
  localparam int CB_LAST    = 4;
  localparam int CB_STOP    = 5;
  localparam int CB_EN      = 16;
  localparam int CB_ADDR_LO = 24;
  // status fields
  localparam int ST_ACK  = 0;
  localparam int ST_NAK  = 1;
  localparam int ST_DONE = 16;
  // buffer fields
  localparam int BF_RX_LO = 8;
  localparam int BF_BUSY  = 16;
  localparam int BF_SDA   = 17;
  localparam int BF_SCL   = 18;

  typedef enum logic [2:0] {
    SEG_IDLE, SEG_HOLD, SEG_START, SEG_BIT, SEG_STOP
  } seg_e;
endpackage

// File: rtl/i2cpm_line.sv
module i2cpm_line
  import i2cpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seg_e       seg,
  input  logic [1:0] q,
  input  logic       bval,
  output logic       scl_l,
  output logic       sda_l
);
  logic scl_d, sda_d;
  seg_e seg_q;

  always_comb begin
    scl_d = 1'b1;
    sda_d = 1'b1;
    case (seg)
      SEG_HOLD:  begin scl_d = 1'b0; sda_d = 1'b1; end
      SEG_START: begin scl_d = (q == 2'd1) || (q == 2'd2); sda_d = (q < 2'd2); end
      SEG_BIT:   begin scl_d = (q == 2'd1) || (q == 2'd2); sda_d = bval; end
      SEG_STOP:  begin scl_d = (q != 2'd0); sda_d = (q >= 2'd2); end
      default:   begin scl_d = 1'b1; sda_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_l <= 1'b1;
      sda_l <= 1'b1;
      seg_q <= SEG_IDLE;
    end else begin
      scl_l <= scl_d;
      sda_l <= sda_d;
      seg_q <= seg;
    end
  end

  // R11: SDA moves under a high SCL only inside START or STOP
  p_sda_steady_r11: assert property (@(posedge clk) disable iff (rst)
    (scl_l && $past(scl_l) && (sda_l != $past(sda_l))) |->
      (seg_q == SEG_START || seg_q == SEG_STOP));
endmodule

// File: rtl/i2cpm_seq.sv
module i2cpm_seq
  import i2cpm_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              go,
  input  logic              c_start,
  input  logic              c_tx,
  input  logic              c_rx,
  input  logic              c_last,
  input  logic              c_stop,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sda_s,
  output logic              busy,
  output logic              held,
  output logic              done,
  output logic              pkt_slot,
  output logic              pkt_nak,
  output logic [BYTE_W-1:0] rx_byte,
  output seg_e              seg,
  output logic [1:0]        q,
  output logic              bval
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);

  typedef enum logic [2:0] {S_IDLE, S_START, S_ADDR, S_DATA, S_STOP} st_e;

  st_e               st;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] shreg;
  logic              f_tx, f_rx, f_last, f_stop;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_data, tgt_slot, at_slot;

  assign rd_data  = (st == S_DATA) && f_rx && !f_tx;
  assign tgt_slot = (st == S_ADDR) || ((st == S_DATA) && !rd_data);
  assign at_slot  = (bitn == ACK_SLOT);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; q <= '0; bitn <= '0; shreg <= '0;
      f_tx <= 1'b0; f_rx <= 1'b0; f_last <= 1'b0; f_stop <= 1'b0;
      addr_q <= '0; held <= 1'b0; done <= 1'b0;
      pkt_slot <= 1'b0; pkt_nak <= 1'b0; rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (go) begin
          f_tx <= c_tx; f_rx <= c_rx; f_last <= c_last; f_stop <= c_stop;
          addr_q <= c_addr; pkt_slot <= 1'b0; pkt_nak <= 1'b0;
          q <= '0; bitn <= '0;
          if (c_start)            st <= S_START;
          else if (c_tx || c_rx) begin st <= S_DATA; shreg <= tx_byte; end
          else if (c_stop)        st <= S_STOP;
          else                    done <= 1'b1;
        end
      end else if (tick) begin
        q <= q + 2'd1;
        case (st)
          S_START: if (q == 2'd3) begin
            st    <= S_ADDR;
            shreg <= BYTE_W'({addr_q, f_rx & ~f_tx});
            bitn  <= '0;
            held  <= 1'b1;
          end
          S_ADDR, S_DATA: begin
            if (q == 2'd2) begin
              if (at_slot) begin
                if (tgt_slot) begin
                  pkt_slot <= 1'b1;
                  if (sda_s) pkt_nak <= 1'b1;
                end
              end else if (rd_data) begin
                shreg <= {shreg[BYTE_W-2:0], sda_s};
              end
            end
            if (q == 2'd3) begin
              if (!at_slot) begin
                bitn <= bitn + 1'b1;
                if (!rd_data) shreg <= {shreg[BYTE_W-2:0], 1'b0};
              end else begin
                bitn <= '0;
                if (rd_data) rx_byte <= shreg;
                if ((st == S_ADDR) && !pkt_nak && (f_tx || f_rx)) begin
                  st    <= S_DATA;
                  shreg <= f_tx ? tx_byte : '0;
                end else if (f_stop) begin
                  st <= S_STOP;
                end else begin
                  st   <= S_IDLE;
                  done <= 1'b1;
                end
              end
            end
          end
          S_STOP: if (q == 2'd3) begin
            st   <= S_IDLE;
            held <= 1'b0;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_START:        seg = SEG_START;
      S_ADDR, S_DATA: seg = SEG_BIT;
      S_STOP:         seg = SEG_STOP;
      default:        seg = held ? SEG_HOLD : SEG_IDLE;
    endcase
    if (at_slot) bval = tgt_slot ? 1'b1 : f_last;
    else         bval = rd_data ? 1'b1 : shreg[BYTE_W-1];
  end

  // R4: completion is a single-cycle event
  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/i2c_pkt_master.sv
module i2c_pkt_master
  import i2cpm_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        txb_we,
  input  logic [7:0]  txb_wdata,
  input  logic        sts_we,
  input  logic [31:0] sts_wdata,
  output logic [31:0] sts_rdata,
  output logic [31:0] buf_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);
  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic [BYTE_W-1:0] txb_q, rx_byte;
  logic ack_q, nak_q, done_q;
  logic go, seq_busy, seq_held, seq_done, seq_slot, seq_nak;
  logic scl_l, sda_l, bval;
  logic [1:0] q;
  seg_e seg;
  logic unused_bits;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin scl_sy[0] <= 1'b1; sda_sy[0] <= 1'b1; end
        else     begin scl_sy[0] <= scl_in; sda_sy[0] <= sda_in; end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin scl_sy[i] <= 1'b1; sda_sy[i] <= 1'b1; end
        else     begin scl_sy[i] <= scl_sy[i-1]; sda_sy[i] <= sda_sy[i-1]; end
      end
    end
  end

  assign go = cmd_we && cmd_wdata[CB_EN] && !seq_busy;
  assign unused_bits = ^{cmd_wdata, sts_wdata, txb_wdata};

  i2cpm_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .go(go),
    .c_start(cmd_wdata[CB_START]), .c_tx(cmd_wdata[CB_TX]),
    .c_rx(cmd_wdata[CB_RX]), .c_last(cmd_wdata[CB_LAST]),
    .c_stop(cmd_wdata[CB_STOP]), .c_addr(cmd_wdata[CB_ADDR_LO +: ADDR_W]),
    .tx_byte(txb_q), .sda_s(sda_sy[SYNC_STAGES-1]),
    .busy(seq_busy), .held(seq_held), .done(seq_done),
    .pkt_slot(seq_slot), .pkt_nak(seq_nak), .rx_byte(rx_byte),
    .seg(seg), .q(q), .bval(bval)
  );

  i2cpm_line u_line (
    .clk(clk), .rst(rst), .seg(seg), .q(q), .bval(bval),
    .scl_l(scl_l), .sda_l(sda_l)
  );

  assign scl_oe = ~scl_l;
  assign sda_oe = ~sda_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      txb_q <= '0; ack_q <= 1'b0; nak_q <= 1'b0; done_q <= 1'b0;
    end else begin
      if (txb_we) txb_q <= txb_wdata[BYTE_W-1:0];
      done_q <= (done_q & ~(sts_we & sts_wdata[ST_DONE])) | seq_done;
      ack_q  <= (ack_q & ~(sts_we & sts_wdata[ST_ACK])) |
                (seq_done & seq_slot & ~seq_nak);
      nak_q  <= (nak_q & ~(sts_we & sts_wdata[ST_NAK])) | (seq_done & seq_nak);
    end
  end

  always_comb begin
    sts_rdata = '0;
    sts_rdata[ST_ACK]  = ack_q;
    sts_rdata[ST_NAK]  = nak_q;
    sts_rdata[ST_DONE] = done_q;
    buf_rdata = '0;
    buf_rdata[BYTE_W-1:0] = txb_q;
    buf_rdata[BF_RX_LO +: BYTE_W] = rx_byte;
    buf_rdata[BF_BUSY] = seq_busy | seq_held;
    buf_rdata[BF_SDA]  = sda_sy[SYNC_STAGES-1];
    buf_rdata[BF_SCL]  = scl_sy[SYNC_STAGES-1];
  end

  // R4: a finished packet always shows up as done
  p_done_sets_r4: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> done_q);
  // R5: a written 1 clears ACK unless a packet finishes that cycle
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (sts_we && sts_wdata[ST_ACK] && !seq_done) |=> !ack_q);
  // R7: a released bus leaves both drivers off
  p_release_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && !seq_held) |=> (!scl_oe && !sda_oe));
  // R8: an owned bus between packets keeps SCL low
  p_hold_low_r8: assert property (@(posedge clk) disable iff (rst)
    (seq_held && !seq_busy) |=> scl_oe);
endmodule

// File: tb/i2c_pkt_master_test.sv
module i2c_pkt_master_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] TADDR = 7'h5A;

  typedef struct packed {
    logic [6:0]  a;
    logic [5:0]  fl;
    logic [7:0]  tx;
    logic [31:0] sts;
    logic [7:0]  rx;
    logic        chk_rx;
    logic [7:0]  wr;
    logic        busy;
  } vec_t;

  // fl: bit5 stop, bit4 last, bit3 rx, bit1 tx, bit0 start
  localparam vec_t VEC [7] = '{
    '{7'h5A, 6'b100011, 8'hC3, 32'h0001_0001, 8'h00, 1'b0, 8'hC3, 1'b0},
    '{7'h11, 6'b100011, 8'h99, 32'h0001_0002, 8'h00, 1'b0, 8'hC3, 1'b0},
    '{7'h5A, 6'b100001, 8'h00, 32'h0001_0001, 8'h00, 1'b0, 8'hC3, 1'b0},
    '{7'h2B, 6'b100001, 8'h00, 32'h0001_0002, 8'h00, 1'b0, 8'hC3, 1'b0},
    '{7'h5A, 6'b111001, 8'h00, 32'h0001_0001, 8'hB4, 1'b1, 8'hC3, 1'b0},
    '{7'h5A, 6'b000011, 8'h6E, 32'h0001_0001, 8'h00, 1'b0, 8'h6E, 1'b1},
    '{7'h5A, 6'b111001, 8'h00, 32'h0001_0001, 8'hB4, 1'b1, 8'h6E, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic cmd_we = 1'b0, txb_we = 1'b0, sts_we = 1'b0;
  logic [31:0] cmd_wdata = '0, sts_wdata = '0;
  logic [7:0]  txb_wdata = '0;
  logic [31:0] sts_rdata, buf_rdata;
  logic scl_oe, sda_oe, scl_w, sda_w;
  int total = 0, bad = 0;

  // behavioural target
  typedef enum logic [1:0] {T_IDLE, T_ADR, T_WR, T_RD} tph_e;
  tph_e t_ph;
  logic t_drv, t_rw, t_mack, t_nakd = 1'b0, t_scl_p, t_sda_p;
  logic [3:0] t_bc;
  logic [7:0] t_sh, t_wr, t_rb, t_alog;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | t_drv);

  i2c_pkt_master uut (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .txb_we(txb_we), .txb_wdata(txb_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata),
    .buf_rdata(buf_rdata), .scl_in(scl_w), .sda_in(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  always @(negedge clk) begin
    t_scl_p <= scl_w;
    t_sda_p <= sda_w;
    if (rst) begin
      t_ph <= T_IDLE; t_bc <= '0; t_drv <= 1'b0; t_rw <= 1'b0; t_mack <= 1'b0;
      t_sh <= '0; t_wr <= '0; t_rb <= '0; t_alog <= '0;
      t_scl_p <= 1'b1; t_sda_p <= 1'b1;
    end else if (t_scl_p && scl_w && t_sda_p && !sda_w) begin
      t_ph <= T_ADR; t_bc <= '0; t_drv <= 1'b0;
    end else if (t_scl_p && scl_w && !t_sda_p && sda_w) begin
      t_ph <= T_IDLE; t_bc <= '0; t_drv <= 1'b0;
    end else if (!t_scl_p && scl_w) begin
      if (t_bc < 4'd8) t_sh <= {t_sh[6:0], sda_w};
      else if (t_ph == T_RD) begin
        t_mack <= !sda_w;
        t_alog <= {t_alog[6:0], !sda_w};
      end
      t_bc <= t_bc + 4'd1;
    end else if (t_scl_p && !scl_w) begin
      if (t_bc == 4'd8) begin
        case (t_ph)
          T_ADR: if (t_sh[7:1] == TADDR) begin t_drv <= 1'b1; t_rw <= t_sh[0]; end
                 else t_ph <= T_IDLE;
          T_WR:  begin t_wr <= t_sh; t_drv <= !t_nakd; end
          default: t_drv <= 1'b0;
        endcase
      end else if (t_bc == 4'd9) begin
        t_bc <= '0;
        case (t_ph)
          T_ADR: if (t_rw) begin t_ph <= T_RD; t_rb <= 8'hB4; t_drv <= 1'b0; end
                 else begin t_ph <= T_WR; t_drv <= 1'b0; end
          T_RD:  if (t_mack) begin t_rb <= t_rb + 8'd1; t_drv <= !t_rb[7] ^ (t_rb[6:0] == 7'h7F); end
                 else begin t_ph <= T_IDLE; t_drv <= 1'b0; end
          default: t_drv <= 1'b0;
        endcase
      end else if (t_ph == T_RD && t_bc >= 4'd1 && t_bc <= 4'd7) begin
        t_drv <= !t_rb[4'd7 - t_bc];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input logic [6:0] a, input logic [5:0] fl);
    return (32'h1 << 16) | ({25'd0, a} << 24) | {26'd0, fl};
  endfunction

  task automatic wr_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wdata = w; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic clr_sts(input logic [31:0] m);
    @(negedge clk); sts_wdata = m; sts_we = 1'b1;
    @(negedge clk); sts_we = 1'b0;
  endtask

  task automatic run_pkt(input logic [6:0] a, input logic [5:0] fl, input logic [7:0] tx,
                         input string req);
    @(negedge clk); txb_wdata = tx; txb_we = 1'b1;
    @(negedge clk); txb_we = 1'b0;
    clr_sts(32'hFFFF_FFFF);
    wr_cmd(mkcmd(a, fl));
    for (int n = 0; n < 5000 && !sts_rdata[16]; n++) @(negedge clk);
    check({req, " done"}, {31'd0, sts_rdata[16]}, 32'd1);
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";
      1: return "R2";
      2, 3: return "R13";
      4: return "R6";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 status", sts_rdata, 32'h0);
    check("R12 busy", {31'd0, buf_rdata[16]}, 32'd0);
    check("R12 drivers", {30'd0, scl_oe, sda_oe}, 32'd0);
    check("R10 idle levels", {30'd0, buf_rdata[18:17]}, 32'd3);

    // R1: command without enable bit
    @(negedge clk); cmd_wdata = mkcmd(TADDR, 6'b100001) & ~32'h0001_0000; cmd_we = 1'b1;
    @(negedge clk); cmd_we = 1'b0;
    check("R1 no start drive", {30'd0, scl_oe, sda_oe}, 32'd0);
    repeat (300) @(negedge clk);
    check("R1 status", sts_rdata, 32'h0);

    for (int i = 0; i < 7; i++) begin
      run_pkt(VEC[i].a, VEC[i].fl, VEC[i].tx, tag_of(i));
      check({tag_of(i), " R4 status"}, sts_rdata, VEC[i].sts);
      check({tag_of(i), " R7 busy"}, {31'd0, buf_rdata[16]}, {31'd0, VEC[i].busy});
      check({tag_of(i), " target wr"}, {24'd0, t_wr}, {24'd0, VEC[i].wr});
      if (VEC[i].chk_rx) check({tag_of(i), " rx byte"}, {24'd0, buf_rdata[15:8]}, {24'd0, VEC[i].rx});
      if (!VEC[i].busy) check("R7 released", {30'd0, scl_oe, sda_oe}, 32'd0);
    end

    // R6: two-byte read, ACK then NACK
    run_pkt(TADDR, 6'b001001, 8'h00, "R6");
    check("R6 first byte", {24'd0, buf_rdata[15:8]}, 32'hB4);
    check("R8 held", {31'd0, buf_rdata[16]}, 32'd1);
    run_pkt(TADDR, 6'b111000, 8'h00, "R6");
    check("R6 second byte", {24'd0, buf_rdata[15:8]}, 32'hB5);
    check("R6 no slot status", sts_rdata, 32'h0001_0000);
    check("R6 master ack/nack", {30'd0, t_alog[1:0]}, 32'd2);

    // R4: data NAK
    t_nakd = 1'b1;
    run_pkt(TADDR, 6'b100011, 8'h11, "R4");
    check("R4 data nak", sts_rdata, 32'h0001_0002);
    t_nakd = 1'b0;

    // R5: write-one-to-clear
    clr_sts(32'h0001_0000);
    check("R5 clear done only", sts_rdata, 32'h0000_0002);
    clr_sts(32'h0000_0002);
    check("R5 clear nak", sts_rdata, 32'h0);

    // R9: command during a packet is ignored
    @(negedge clk); txb_wdata = 8'h42; txb_we = 1'b1;
    @(negedge clk); txb_we = 1'b0;
    wr_cmd(mkcmd(TADDR, 6'b000011));
    repeat (20) @(negedge clk);
    wr_cmd(mkcmd(7'h2B, 6'b100001));
    for (int n = 0; n < 5000 && !sts_rdata[16]; n++) @(negedge clk);
    repeat (300) @(negedge clk);
    check("R9 status", sts_rdata, 32'h0001_0001);
    check("R9 busy kept", {31'd0, buf_rdata[16]}, 32'd1);
    check("R9 byte", {24'd0, t_wr}, 32'h42);
    check("R8 scl low", {31'd0, scl_oe}, 32'd1);
    check("R10 scl level", {31'd0, buf_rdata[18]}, 32'd0);
    run_pkt(TADDR, 6'b100000, 8'h00, "R7");
    check("R7 stop status", sts_rdata, 32'h0001_0000);
    check("R7 busy clear", {31'd0, buf_rdata[16]}, 32'd0);
    check("R7 lines free", {30'd0, scl_oe, sda_oe}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule